// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt request sources for a small processor core: two active-low external pins, two timer overflow pulses, a serial event and a third timer request. Each source is held in a pending flag. The flag is masked by its own enable bit and by a global enable bit. Among the requests that survive the masks, the controller picks one and presents its index as a vector. The core takes the vector with an acknowledge handshake and later signals the end of that service.

Each source has a one-bit priority that selects one of two levels. A high-level request can interrupt a low-level service. Nothing interrupts a high-level service, and nothing interrupts a service at its own level. Each external pin has its own trigger mode, either level or falling edge. On acknowledge, edge-mode pin flags and the two timer overflow flags are cleared by hardware. Level-mode flags follow the pin. The serial flag and the third timer flag follow their inputs.

Top module: `irqc_top`

## Requirements
- R1: After reset, `irq_valid` and `irq_pend` are 0, all enable and priority bits are 0, and both pins are in level mode.
- R2: While enable bit 7 (global) is 0, `irq_valid` stays 0 whatever is pending.
- R3: Source index and enable bit position are the same: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial, 5 timer 2. A source whose enable bit is 0 is never presented.
- R4: When a high-level candidate exists (priority bit 1), it wins. Within a level the lowest index wins, and `irq_vec` is that index. `irq_hi` gives the level of the presented source.
- R5: In level mode (mode bit 0), the pending flag of a pin is set while the pin is low. Acknowledge does not clear it, so the pin requests again after end of service if it is still low.
- R6: In edge mode (mode bit 1), a high sample followed by a low sample sets the flag once, and acknowledge of that vector clears it. A pin held low does not set the flag again.
- R7: A timer 0 or timer 1 overflow pulse sets a flag. The flag stays set until its vector is acknowledged.
- R8: The serial request is the OR of receive-done and transmit-done. Acknowledge does not clear it.
- R9: While a low-level service is active, only high-level sources are presented. While a high-level service is active, nothing is presented.
- R10: An `irq_eoi` pulse ends the most recently entered level, high before low.
- R11: `irq_valid` is 0 in the cycle after an acknowledge.
- R12: `irq_pend` shows the pending flag of each source, with bit i belonging to source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable value; bit 7 global, bits 0-5 per source |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 6 | Priority value; 1 means high level |
| mode_we | input | 1 | Write strobe for the trigger modes |
| mode_wdata | input | 2 | Trigger mode of pin 0 (bit 0) and pin 1 (bit 1); 1 means edge |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Overflow pulses of timer 0 (bit 0) and timer 1 (bit 1) |
| ser_rx_done | input | 1 | Serial receive-done flag |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| tmr2_req | input | 1 | Timer 2 request level |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_eoi | input | 1 | End-of-service pulse |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | 3 | Index of the presented source |
| irq_hi | output | 1 | Level of the presented source |
| irq_pend | output | 6 | Pending flags |

## Verification
The bench builds the block with its default parameters: six sources, an 8-bit enable register with the global bit at 7, and two external pins. This makes every source position, both trigger modes and both timer flags reachable. Directed sequences walk through nesting: a low-level service, preemption by a high-level source, and two end-of-service pulses in turn. A seeded random phase tries many enable, priority and request patterns and compares each result against an arbitration function written in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQ_NUM_SRC = 6;
  localparam int IRQ_VEC_W   = $clog2(IRQ_NUM_SRC);
  localparam int IRQ_EN_W    = 8;
  localparam int IRQ_GEN_BIT = 7;
  localparam int IRQ_NUM_EXT = 2;

  // source positions, shared by enable, priority and vector index
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;
  localparam int SRC_TMR2 = 5;

  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} irq_lvl_e;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int NUM_SRC = irqc_pkg::IRQ_NUM_SRC,
  parameter int NUM_EXT = irqc_pkg::IRQ_NUM_EXT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] ext_n,
  input  logic [NUM_EXT-1:0] edge_mode,
  input  logic [NUM_EXT-1:0] tmr_ovf,
  input  logic               ser_rx_done,
  input  logic               ser_tx_done,
  input  logic               tmr2_req,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_EXT-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '1;
    else     pin_q <= ext_n;
  end

  // external pins sit on even indices, their timers on the next odd index
  for (genvar i = 0; i < NUM_EXT; i++) begin : g_pair
    localparam int EI = 2 * i;
    localparam int TI = 2 * i + 1;
    logic fall;
    assign fall = pin_q[i] & ~ext_n[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pend[EI] <= 1'b0;
      end else if (!edge_mode[i]) begin
        pend[EI] <= ~ext_n[i];
      end else if (fall) begin
        pend[EI] <= 1'b1;
      end else if (clr[EI]) begin
        pend[EI] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)               pend[TI] <= 1'b0;
      else if (tmr_ovf[i])   pend[TI] <= 1'b1;
      else if (clr[TI])      pend[TI] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend[irqc_pkg::SRC_SER]  <= 1'b0;
      pend[irqc_pkg::SRC_TMR2] <= 1'b0;
    end else begin
      pend[irqc_pkg::SRC_SER]  <= ser_rx_done | ser_tx_done;
      pend[irqc_pkg::SRC_TMR2] <= tmr2_req;
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = irqc_pkg::IRQ_NUM_SRC,
  parameter int VEC_W   = irqc_pkg::IRQ_VEC_W
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] pri,
  input  logic               allow_hi,
  input  logic               allow_lo,
  output logic               any,
  output logic [VEC_W-1:0]   vec,
  output logic               hi
);
  logic [NUM_SRC-1:0] cand_hi;
  logic [NUM_SRC-1:0] cand_lo;
  logic [NUM_SRC-1:0] cand;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
    assign cand_hi[i] = req[i] &  pri[i] & allow_hi;
    assign cand_lo[i] = req[i] & ~pri[i] & allow_lo;
  end

  assign hi   = |cand_hi;
  assign cand = hi ? cand_hi : cand_lo;
  assign any  = |cand;

  // scan downward so the lowest index is left standing
  always_comb begin
    vec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) vec = VEC_W'(i);
    end
  end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest (
  input  logic clk,
  input  logic rst,
  input  logic ack_fire,
  input  logic ack_hi,
  input  logic eoi,
  output logic act_hi,
  output logic act_lo
);
  logic hi_d;
  logic lo_d;

  always_comb begin
    hi_d = act_hi;
    lo_d = act_lo;
    if (eoi) begin
      if (act_hi) hi_d = 1'b0;
      else        lo_d = 1'b0;
    end
    if (ack_fire) begin
      if (ack_hi) hi_d = 1'b1;
      else        lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else begin
      act_hi <= hi_d;
      act_lo <= lo_d;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NUM_SRC = irqc_pkg::IRQ_NUM_SRC,
  parameter int VEC_W   = irqc_pkg::IRQ_VEC_W,
  parameter int EN_W    = irqc_pkg::IRQ_EN_W,
  parameter int GEN_BIT = irqc_pkg::IRQ_GEN_BIT,
  parameter int NUM_EXT = irqc_pkg::IRQ_NUM_EXT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_we,
  input  logic [EN_W-1:0]    en_wdata,
  input  logic               pri_we,
  input  logic [NUM_SRC-1:0] pri_wdata,
  input  logic               mode_we,
  input  logic [NUM_EXT-1:0] mode_wdata,
  input  logic [NUM_EXT-1:0] ext_n,
  input  logic [NUM_EXT-1:0] tmr_ovf,
  input  logic               ser_rx_done,
  input  logic               ser_tx_done,
  input  logic               tmr2_req,
  input  logic               irq_ack,
  input  logic               irq_eoi,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               irq_hi,
  output logic [NUM_SRC-1:0] irq_pend
);
  logic [EN_W-1:0]    en_q;
  logic [NUM_SRC-1:0] pri_q;
  logic [NUM_EXT-1:0] mode_q;
  logic               act_hi;
  logic               act_lo;
  logic               ack_fire;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] clearable;
  logic [NUM_SRC-1:0] req;
  logic               cand_any;
  logic [VEC_W-1:0]   cand_vec;
  logic               cand_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pri_q  <= '0;
      mode_q <= '0;
    end else begin
      if (en_we)   en_q   <= en_wdata;
      if (pri_we)  pri_q  <= pri_wdata;
      if (mode_we) mode_q <= mode_wdata;
    end
  end

  assign ack_fire = irq_valid & irq_ack;

  // edge-mode pins and the paired timers lose their flag on acknowledge
  for (genvar i = 0; i < NUM_EXT; i++) begin : g_clrmask
    assign clearable[2*i]   = mode_q[i];
    assign clearable[2*i+1] = 1'b1;
  end
  for (genvar j = 2 * NUM_EXT; j < NUM_SRC; j++) begin : g_noclr
    assign clearable[j] = 1'b0;
  end

  always_comb begin
    clr = '0;
    if (ack_fire) clr[irq_vec] = 1'b1;
    clr = clr & clearable;
  end

  irqc_capture #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) cap_i (
    .clk         (clk),
    .rst         (rst),
    .ext_n       (ext_n),
    .edge_mode   (mode_q),
    .tmr_ovf     (tmr_ovf),
    .ser_rx_done (ser_rx_done),
    .ser_tx_done (ser_tx_done),
    .tmr2_req    (tmr2_req),
    .clr         (clr),
    .pend        (irq_pend)
  );

  assign req = irq_pend & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[GEN_BIT]}};

  irqc_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) arb_i (
    .req      (req),
    .pri      (pri_q),
    .allow_hi (~act_hi),
    .allow_lo (~act_hi & ~act_lo),
    .any      (cand_any),
    .vec      (cand_vec),
    .hi       (cand_hi)
  );

  irqc_nest nest_i (
    .clk      (clk),
    .rst      (rst),
    .ack_fire (ack_fire),
    .ack_hi   (irq_hi),
    .eoi      (irq_eoi),
    .act_hi   (act_hi),
    .act_lo   (act_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_hi    <= 1'b0;
    end else begin
      irq_valid <= cand_any & ~ack_fire;
      irq_vec   <= cand_vec;
      irq_hi    <= cand_hi;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NUM_SRC = 6,
  parameter int VEC_W   = 3,
  parameter int EN_W    = 8,
  parameter int GEN_BIT = 7,
  parameter int NUM_EXT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_valid,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               irq_hi,
  input logic               irq_ack,
  input logic               act_hi,
  input logic               act_lo,
  input logic [EN_W-1:0]    en_q,
  input logic [NUM_EXT-1:0] tmr_ovf,
  input logic [NUM_SRC-1:0] irq_pend
);
  p_gate_r2: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(en_q[GEN_BIT]));

  p_src_en_r3: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ((($past(en_q) >> irq_vec) & EN_W'(1)) == EN_W'(1)));

  p_vec_range_r4: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (int'(irq_vec) < NUM_SRC));

  p_tmr_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ack && irq_vec == VEC_W'(1) && !tmr_ovf[0]) |=> !irq_pend[1]);

  p_hi_block_r9: assert property (@(posedge clk) disable iff (rst)
    act_hi |-> !irq_valid);

  p_lo_block_r9: assert property (@(posedge clk) disable iff (rst)
    (act_lo && irq_valid) |-> irq_hi);

  p_ack_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ack) |=> !irq_valid);
endmodule

bind irqc_top irqc_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .EN_W(EN_W), .GEN_BIT(GEN_BIT), .NUM_EXT(NUM_EXT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .irq_valid (irq_valid),
  .irq_vec   (irq_vec),
  .irq_hi    (irq_hi),
  .irq_ack   (irq_ack),
  .act_hi    (act_hi),
  .act_lo    (act_lo),
  .en_q      (en_q),
  .tmr_ovf   (tmr_ovf),
  .irq_pend  (irq_pend)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_we = 1'b0;
  logic [7:0] en_wdata = '0;
  logic       pri_we = 1'b0;
  logic [5:0] pri_wdata = '0;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = '0;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] tmr_ovf = '0;
  logic       ser_rx_done = 1'b0;
  logic       ser_tx_done = 1'b0;
  logic       tmr2_req = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_eoi = 1'b0;
  logic       irq_valid;
  logic [2:0] irq_vec;
  logic       irq_hi;
  logic [5:0] irq_pend;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst(rst),
    .en_we(en_we), .en_wdata(en_wdata),
    .pri_we(pri_we), .pri_wdata(pri_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ext_n(ext_n), .tmr_ovf(tmr_ovf),
    .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done), .tmr2_req(tmr2_req),
    .irq_ack(irq_ack), .irq_eoi(irq_eoi),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_hi(irq_hi), .irq_pend(irq_pend)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(logic [7:0] v);
    en_wdata = v; en_we = 1'b1; tick(1); en_we = 1'b0;
  endtask

  task automatic wr_pri(logic [5:0] v);
    pri_wdata = v; pri_we = 1'b1; tick(1); pri_we = 1'b0;
  endtask

  task automatic wr_mode(logic [1:0] v);
    mode_wdata = v; mode_we = 1'b1; tick(1); mode_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
  endtask

  task automatic eoi();
    irq_eoi = 1'b1; tick(1); irq_eoi = 1'b0;
  endtask

  // reference arbitration: -1 when nothing may be presented
  function automatic int pick(logic [7:0] en, logic [5:0] pri, logic [5:0] pend);
    logic [5:0] r;
    r = pend & en[5:0] & {6{en[7]}};
    for (int i = 0; i < 6; i++) if (r[i] && pri[i]) return i;
    for (int i = 0; i < 6; i++) if (r[i]) return i;
    return -1;
  endfunction

  initial begin
    #(10 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1129);
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 valid after reset", irq_valid, 0);
    chk("R1 pend after reset", irq_pend, 0);

    // global enable off
    ext_n[0] = 1'b0;
    wr_en(8'h3F);
    tick(3);
    chk("R12 pend follows low pin", irq_pend[0], 1);
    chk("R2 global off blocks", irq_valid, 0);
    wr_en(8'hBF);
    tick(3);
    chk("R3 ext0 valid", irq_valid, 1);
    chk("R3 ext0 vector", irq_vec, 0);
    wr_en(8'hBE);
    tick(3);
    chk("R3 disabled source hidden", irq_valid, 0);
    ext_n[0] = 1'b1;

    // serial source
    wr_en(8'h90);
    ser_rx_done = 1'b1;
    tick(3);
    chk("R8 serial vector", irq_vec, 4);
    chk("R8 serial valid", irq_valid, 1);
    ack();
    chk("R11 valid drops after ack", irq_valid, 0);
    chk("R8 serial flag kept", irq_pend[4], 1);
    eoi();
    ser_rx_done = 1'b0;
    ser_tx_done = 1'b1;
    tick(3);
    chk("R8 tx-done requests", irq_valid, 1);
    ser_tx_done = 1'b0;
    tick(3);
    chk("R8 serial idle", irq_valid, 0);

    // priority
    wr_en(8'hBF);
    wr_pri(6'h00);
    ext_n[1] = 1'b0;
    tmr2_req = 1'b1;
    tick(3);
    chk("R4 lowest index wins", irq_vec, 2);
    wr_pri(6'h20);
    tick(3);
    chk("R4 high level wins", irq_vec, 5);
    chk("R4 level reported", irq_hi, 1);
    wr_pri(6'h24);
    tick(3);
    chk("R4 order inside high level", irq_vec, 2);

    // nesting
    wr_pri(6'h20);
    tmr2_req = 1'b0;
    tick(3);
    chk("R9 low source presented", irq_vec, 2);
    chk("R9 low source level", irq_hi, 0);
    ack();
    tick(4);
    chk("R9 low service blocks low", irq_valid, 0);
    tmr2_req = 1'b1;
    tick(3);
    chk("R9 preempt valid", irq_valid, 1);
    chk("R9 preempt vector", irq_vec, 5);
    ack();
    tmr2_req = 1'b0;
    tick(3);
    chk("R9 high service blocks all", irq_valid, 0);
    eoi();
    tick(3);
    chk("R10 low level still active", irq_valid, 0);
    eoi();
    tick(3);
    chk("R10 after second eoi", irq_valid, 1);
    chk("R5 level pin requests again", irq_vec, 2);
    ext_n[1] = 1'b1;
    tick(3);
    chk("R5 pin released", irq_valid, 0);

    // edge mode on pin 0
    wr_mode(2'b01);
    wr_en(8'h81);
    wr_pri(6'h00);
    ext_n[0] = 1'b0;
    tick(3);
    chk("R6 edge sets flag", irq_pend[0], 1);
    chk("R6 edge vector", irq_valid, 1);
    ack();
    chk("R6 edge flag cleared", irq_pend[0], 0);
    eoi();
    tick(3);
    chk("R6 held low no retrigger", irq_valid, 0);
    ext_n[0] = 1'b1;
    tick(1);

    // timers
    wr_en(8'h8A);
    tmr_ovf = 2'b11;
    tick(1);
    tmr_ovf = 2'b00;
    tick(3);
    chk("R7 timer0 first", irq_vec, 1);
    chk("R7 both flags", irq_pend & 6'h0A, 10);
    ack();
    chk("R7 timer0 cleared", irq_pend[1], 0);
    chk("R7 timer1 kept", irq_pend[3], 1);
    eoi();
    tick(3);
    chk("R7 timer1 next", irq_vec, 3);
    ack();
    chk("R7 timer1 cleared", irq_pend[3], 0);
    eoi();
    tick(3);
    chk("R7 timers idle", irq_valid, 0);

    // random patterns, level mode, no timers
    wr_mode(2'b00);
    for (int k = 0; k < 60; k++) begin
      logic [7:0] en;
      logic [5:0] pr;
      logic [5:0] pd;
      int exp;
      en = 8'($urandom);
      pr = 6'($urandom);
      ext_n = 2'($urandom);
      ser_rx_done = 1'($urandom);
      ser_tx_done = 1'($urandom);
      tmr2_req = 1'($urandom);
      wr_en(en);
      wr_pri(pr);
      tick(3);
      pd = {tmr2_req, ser_rx_done | ser_tx_done, 1'b0, ~ext_n[1], 1'b0, ~ext_n[0]};
      exp = pick(en, pr, pd);
      chk("R12 random pend", irq_pend, pd);
      chk("R3 random valid", irq_valid, (exp >= 0) ? 1 : 0);
      if (exp >= 0) chk("R4 random vector", irq_vec, exp);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule